// File: doc/BRIEF.md
# Register-Format ALU Execute Unit

This block takes instruction halfwords from an upstream fetch stage, marked by a valid strobe. It decodes a small integer subset and executes each instruction in one clock against its own 32 x 32-bit register file. It also keeps four condition flags: carry/borrow, overflow, sign and zero.

The subset covers:
- subtraction in both operand orders;
- a bitwise-AND test that only sets flags;
- register XOR, and XOR with a 16-bit immediate taken from the next halfword;
- in-place zero or sign extension of the low byte or low halfword.

Any other encoding raises a one-cycle illegal pulse and changes no state. A combinational peek port lets the surrounding logic read any register.

Top module: `alu_exu`

## Requirements
- R1: After reset every register reads zero, all four flags are 0 and illegalOp is 0.
- R2: An instruction halfword holds reg2 in bits 15:11, the opcode in bits 10:5 and reg1 in bits 4:0. Register 0 always reads zero, and a write to it is discarded.
- R3: Opcode 001101 writes reg2 - reg1 into reg2. CY is the borrow out of the top bit. OV is set when the operands differ in sign and the result's sign differs from the minuend's. S is result bit 31 and Z marks a zero result.
- R4: Opcode 001100 writes reg1 - reg2 into reg2. Its flags follow R3, with reg1 as the minuend.
- R5: Opcode 001011 computes reg2 AND reg1 and writes no register. S and Z follow the AND result, OV becomes 0 and CY is kept.
- R6: Opcode 001001 writes reg2 XOR reg1 into reg2. S and Z follow the result, OV becomes 0 and CY is kept.
- R7: Opcode 110101 takes the next valid halfword as imm16 and writes reg1 XOR zero-extended imm16 into reg2. Its flags follow R6. Cycles with the valid strobe low between the two halfwords are waited out, and the first halfword alone changes nothing.
- R8: When the reg2 field is 00000, these opcodes rewrite reg1 in place and leave all flags unchanged: 000100 zero-extends the low byte, 000101 sign-extends the low byte, 000110 zero-extends the low halfword and 000111 sign-extends the low halfword.
- R9: Every instruction completes at the clock edge that accepts its last halfword. The next instruction, issued on the following cycle, sees that result.
- R10: Any other opcode, or an extension opcode with a nonzero reg2 field, pulses illegalOp high for the one cycle after acceptance and changes no register and no flag. A cycle with instrValid low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | instrHalf carries a halfword this cycle |
| instrHalf | input | 16 | Instruction or immediate halfword |
| peekAddr | input | 5 | Register index for the read port |
| peekData | output | DATA_W | Contents of the selected register |
| flagCy | output | 1 | Carry/borrow flag |
| flagOv | output | 1 | Overflow flag |
| flagS | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |
| illegalOp | output | 1 | One-cycle pulse for a rejected halfword |

## Verification
The bench builds the unit with the default DATA_W of 32. At that width, the borrow and signed-overflow corners at the 0x80000000 and 0xFFFFFFFF boundaries can be reached exactly. It builds those values from immediates with chains of subtractions, then runs a long seeded random mix of legal, illegal and split-immediate instructions. All random instructions issue back to back, with random idle gaps inside the immediate pairs, so stale-operand forwarding mistakes and skipped-gap mistakes would both show up.

// File: rtl/alu_exu_pkg.sv
package alu_exu_pkg;
  localparam int FIELD_W = 5;
  localparam int REG_N = 1 << FIELD_W;

  localparam logic [5:0] OPC_SUB  = 6'b001101;
  localparam logic [5:0] OPC_SUBR = 6'b001100;
  localparam logic [5:0] OPC_TST  = 6'b001011;
  localparam logic [5:0] OPC_XOR  = 6'b001001;
  localparam logic [5:0] OPC_XORI = 6'b110101;
  localparam logic [5:0] OPC_ZXB  = 6'b000100;
  localparam logic [5:0] OPC_SXB  = 6'b000101;
  localparam logic [5:0] OPC_ZXH  = 6'b000110;
  localparam logic [5:0] OPC_SXH  = 6'b000111;

  typedef enum logic [3:0] {
    OP_SUB, OP_SUBR, OP_TST, OP_XOR, OP_XORI, OP_ZXB, OP_SXB, OP_ZXH, OP_SXH
  } aluOp_e;

  typedef struct packed {
    logic               exec;      // commit this cycle
    aluOp_e             op;
    logic [FIELD_W-1:0] srcA;      // reg1 field
    logic [FIELD_W-1:0] srcB;      // reg2 field
    logic [FIELD_W-1:0] dst;
    logic [15:0]        imm;
    logic               wrEn;      // write result to dst
    logic               setArith;  // CY, OV, S, Z from subtractor
    logic               setLogic;  // S, Z from result, OV cleared
  } exuCtrl_t;
endpackage

// File: rtl/alu_exu_ctrl.sv
module alu_exu_ctrl
  import alu_exu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrHalf,
  output exuCtrl_t    ctrl,
  output logic        illegalOp
);
  typedef enum logic {ST_HEAD, ST_IMM} seqState_e;

  seqState_e          state;
  logic [FIELD_W-1:0] pendR1, pendR2;
  logic               illegalQ;

  logic [FIELD_W-1:0] fieldR2, fieldR1;
  logic [5:0]         opcode;
  logic               legal;
  logic               isImmHead;
  exuCtrl_t           headCtrl;

  assign fieldR2 = instrHalf[15:11];
  assign opcode  = instrHalf[10:5];
  assign fieldR1 = instrHalf[4:0];

  always_comb begin
    headCtrl          = '0;
    headCtrl.op       = OP_SUB;
    headCtrl.srcA     = fieldR1;
    headCtrl.srcB     = fieldR2;
    headCtrl.dst      = fieldR2;
    headCtrl.imm      = '0;
    legal             = 1'b1;
    isImmHead         = 1'b0;
    unique case (opcode)
      OPC_SUB:  begin headCtrl.op = OP_SUB;  headCtrl.wrEn = 1'b1; headCtrl.setArith = 1'b1; end
      OPC_SUBR: begin headCtrl.op = OP_SUBR; headCtrl.wrEn = 1'b1; headCtrl.setArith = 1'b1; end
      OPC_TST:  begin headCtrl.op = OP_TST;  headCtrl.setLogic = 1'b1; end
      OPC_XOR:  begin headCtrl.op = OP_XOR;  headCtrl.wrEn = 1'b1; headCtrl.setLogic = 1'b1; end
      OPC_XORI: isImmHead = 1'b1;
      OPC_ZXB, OPC_SXB, OPC_ZXH, OPC_SXH: begin
        legal         = (fieldR2 == '0);
        headCtrl.wrEn = 1'b1;
        headCtrl.dst  = fieldR1;
        case (opcode)
          OPC_ZXB: headCtrl.op = OP_ZXB;
          OPC_SXB: headCtrl.op = OP_SXB;
          OPC_ZXH: headCtrl.op = OP_ZXH;
          default: headCtrl.op = OP_SXH;
        endcase
      end
      default: legal = 1'b0;
    endcase
    headCtrl.exec = instrValid && legal && !isImmHead;
  end

  always_comb begin
    if (state == ST_IMM) begin
      ctrl          = '0;
      ctrl.exec     = instrValid;
      ctrl.op       = OP_XORI;
      ctrl.srcA     = pendR1;
      ctrl.srcB     = pendR2;
      ctrl.dst      = pendR2;
      ctrl.imm      = instrHalf;
      ctrl.wrEn     = 1'b1;
      ctrl.setLogic = 1'b1;
    end else begin
      ctrl = headCtrl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HEAD;
      pendR1   <= '0;
      pendR2   <= '0;
      illegalQ <= 1'b0;
    end else begin
      illegalQ <= instrValid && (state == ST_HEAD) && !legal;
      if (instrValid) begin
        if (state == ST_HEAD && isImmHead) begin
          state  <= ST_IMM;
          pendR1 <= fieldR1;
          pendR2 <= fieldR2;
        end else begin
          state <= ST_HEAD;
        end
      end
    end
  end

  assign illegalOp = illegalQ;
endmodule

// File: rtl/alu_exu_dpath.sv
module alu_exu_dpath
  import alu_exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  exuCtrl_t           ctrl,
  input  logic [FIELD_W-1:0] peekAddr,
  output logic [DATA_W-1:0]  peekData,
  output logic               flagCy,
  output logic               flagOv,
  output logic               flagS,
  output logic               flagZ
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] gpr [1:REG_N-1];
  logic [DATA_W-1:0] opA, opB, minuend, subtrahend, diff, result;
  logic [DATA_W:0]   wideDiff;
  logic              borrow, overflow;

  function automatic logic [DATA_W-1:0] readReg(input logic [FIELD_W-1:0] idx);
    return (idx == '0) ? '0 : gpr[idx];
  endfunction

  assign opA      = readReg(ctrl.srcA);
  assign opB      = readReg(ctrl.srcB);
  assign peekData = readReg(peekAddr);

  // One subtractor serves both operand orders
  always_comb begin
    if (ctrl.op == OP_SUBR) begin
      minuend    = opA;
      subtrahend = opB;
    end else begin
      minuend    = opB;
      subtrahend = opA;
    end
  end

  assign wideDiff = {1'b0, minuend} - {1'b0, subtrahend};
  assign diff     = wideDiff[DATA_W-1:0];
  assign borrow   = wideDiff[DATA_W];
  assign overflow = (minuend[MSB] ^ subtrahend[MSB]) & (diff[MSB] ^ minuend[MSB]);

  always_comb begin
    unique case (ctrl.op)
      OP_SUB, OP_SUBR: result = diff;
      OP_TST:          result = opB & opA;
      OP_XOR:          result = opB ^ opA;
      OP_XORI:         result = opA ^ {{(DATA_W-16){1'b0}}, ctrl.imm};
      OP_ZXB:          result = {{(DATA_W-8){1'b0}}, opA[7:0]};
      OP_SXB:          result = {{(DATA_W-8){opA[7]}}, opA[7:0]};
      OP_ZXH:          result = {{(DATA_W-16){1'b0}}, opA[15:0]};
      default:         result = {{(DATA_W-16){opA[15]}}, opA[15:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 1; i < REG_N; i++) gpr[i] <= '0;
    end else if (ctrl.exec && ctrl.wrEn && ctrl.dst != '0) begin
      gpr[ctrl.dst] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagCy <= 1'b0;
      flagOv <= 1'b0;
      flagS  <= 1'b0;
      flagZ  <= 1'b0;
    end else if (ctrl.exec) begin
      if (ctrl.setArith) begin
        flagCy <= borrow;
        flagOv <= overflow;
      end
      if (ctrl.setLogic) flagOv <= 1'b0;
      if (ctrl.setArith || ctrl.setLogic) begin
        flagS <= result[MSB];
        flagZ <= (result == '0);
      end
    end
  end
endmodule

// File: rtl/alu_exu.sv
module alu_exu
  import alu_exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [15:0]        instrHalf,
  input  logic [FIELD_W-1:0] peekAddr,
  output logic [DATA_W-1:0]  peekData,
  output logic               flagCy,
  output logic               flagOv,
  output logic               flagS,
  output logic               flagZ,
  output logic               illegalOp
);
  exuCtrl_t ctrlBus;

  alu_exu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrValid(instrValid),
    .instrHalf (instrHalf),
    .ctrl      (ctrlBus),
    .illegalOp (illegalOp)
  );

  alu_exu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .peekAddr(peekAddr),
    .peekData(peekData),
    .flagCy  (flagCy),
    .flagOv  (flagOv),
    .flagS   (flagS),
    .flagZ   (flagZ)
  );
endmodule

// File: rtl/alu_exu_chk.sv
module alu_exu_chk
  import alu_exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrValid,
  input logic [FIELD_W-1:0] peekAddr,
  input logic [DATA_W-1:0]  peekData,
  input logic               flagCy,
  input logic               flagOv,
  input logic               flagS,
  input logic               flagZ,
  input logic               illegalOp,
  input exuCtrl_t           ctrlBus
);
  logic isExt;
  assign isExt = ctrlBus.op inside {OP_ZXB, OP_SXB, OP_ZXH, OP_SXH};

  // R2
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (peekAddr == '0) |-> (peekData == '0));

  // R3
  sign_zero_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flagS && flagZ));

  // R5
  tst_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.exec && ctrlBus.op == OP_TST) |=> (!flagOv && $stable(flagCy)));

  // R6
  xor_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.exec && (ctrlBus.op == OP_XOR || ctrlBus.op == OP_XORI))
      |=> (!flagOv && $stable(flagCy)));

  // R8
  ext_flags_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.exec && isExt) |=> $stable({flagCy, flagOv, flagS, flagZ}));

  // R9
  exec_on_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.exec |-> instrValid);

  // R10
  idle_no_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> !illegalOp);

  // R10
  illegal_flags_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> $stable({flagCy, flagOv, flagS, flagZ}));
endmodule

bind alu_exu alu_exu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrValid(instrValid),
  .peekAddr  (peekAddr),
  .peekData  (peekData),
  .flagCy    (flagCy),
  .flagOv    (flagOv),
  .flagS     (flagS),
  .flagZ     (flagZ),
  .illegalOp (illegalOp),
  .ctrlBus   (ctrlBus)
);

// File: tb/alu_exu_tb.sv
module alu_exu_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instrValid = 1'b0;
  logic [15:0]   instrHalf = '0;
  logic [4:0]    peekAddr = '0;
  logic [DW-1:0] peekData;
  logic          flagCy, flagOv, flagS, flagZ, illegalOp;

  int nChecks = 0;
  int nFail = 0;

  logic [DW-1:0] mReg [0:31];
  logic mCy, mOv, mS, mZ, mIll;

  always #5 clk = ~clk;

  alu_exu #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrHalf(instrHalf),
    .peekAddr(peekAddr), .peekData(peekData), .flagCy(flagCy), .flagOv(flagOv),
    .flagS(flagS), .flagZ(flagZ), .illegalOp(illegalOp)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  task automatic checkEq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] peek(input logic [4:0] a);
    return a == 0 ? '0 : mReg[a];
  endfunction

  task automatic readReg(input logic [4:0] a, output logic [DW-1:0] v);
    peekAddr = a;
    #1;
    v = peekData;
  endtask

  function automatic bit isLegal(input logic [5:0] opc, input logic [4:0] r2);
    case (opc)
      6'b001101, 6'b001100, 6'b001011, 6'b001001, 6'b110101: return 1'b1;
      6'b000100, 6'b000101, 6'b000110, 6'b000111: return r2 == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqOf(input logic [5:0] opc, input logic [4:0] r2);
    if (!isLegal(opc, r2)) return "R10";
    case (opc)
      6'b001101: return "R3";
      6'b001100: return "R4";
      6'b001011: return "R5";
      6'b001001: return "R6";
      6'b110101: return "R7";
      default:   return "R8";
    endcase
  endfunction

  // Model of one instruction per the requirements; returns destination
  task automatic modelApply(input logic [15:0] hw, input logic [15:0] imm, output logic [4:0] dst);
    logic [4:0] r2, r1;
    logic [5:0] opc;
    logic [DW-1:0] a, b, r;
    r2 = hw[15:11]; opc = hw[10:5]; r1 = hw[4:0];
    a = peek(r1); b = peek(r2);
    dst = r2;
    mIll = 1'b0;
    case (opc)
      6'b001101: begin r = b - a; mCy = b < a; mOv = (b[31] ^ a[31]) & (r[31] ^ b[31]); end
      6'b001100: begin r = a - b; mCy = a < b; mOv = (a[31] ^ b[31]) & (r[31] ^ a[31]); end
      6'b001011: begin r = a & b; mOv = 1'b0; end
      6'b001001: begin r = a ^ b; mOv = 1'b0; end
      6'b110101: begin r = a ^ {16'h0, imm}; mOv = 1'b0; end
      default: r = '0;
    endcase
    if (!isLegal(opc, r2)) begin
      mIll = 1'b1;
    end else if (opc[5:2] == 4'b0001) begin
      dst = r1;
      case (opc[1:0])
        2'b00: r = {24'h0, a[7:0]};
        2'b01: r = {{24{a[7]}}, a[7:0]};
        2'b10: r = {16'h0, a[15:0]};
        default: r = {{16{a[15]}}, a[15:0]};
      endcase
      if (dst != 0) mReg[dst] = r;
    end else begin
      mS = r[31];
      mZ = (r == 0);
      if (opc != 6'b001011 && dst != 0) mReg[dst] = r;
    end
  endtask

  task automatic pushHalf(input logic [15:0] h);
    instrValid = 1'b1;
    instrHalf = h;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    instrHalf = $urandom();
  endtask

  task automatic runInstr(input logic [15:0] hw, input logic [15:0] imm, input int gap);
    logic [4:0] dst;
    logic [DW-1:0] v;
    string tag;
    tag = reqOf(hw[10:5], hw[15:11]);
    if (hw[10:5] == 6'b110101) begin
      pushHalf(hw);
      checkEq("R7 head alone no pulse", {31'h0, illegalOp}, '0);
      checkEq("R7 head alone flags", {28'h0, flagCy, flagOv, flagS, flagZ},
              {28'h0, mCy, mOv, mS, mZ});
      repeat (gap) @(negedge clk);
      pushHalf(imm);
    end else begin
      pushHalf(hw);
    end
    modelApply(hw, imm, dst);
    checkEq({tag, " illegal"}, {31'h0, illegalOp}, {31'h0, mIll});
    checkEq({tag, " flags"}, {28'h0, flagCy, flagOv, flagS, flagZ}, {28'h0, mCy, mOv, mS, mZ});
    readReg(dst, v);
    checkEq({tag, " dest R2 R9"}, v, peek(dst));
  endtask

  function automatic logic [15:0] enc(input logic [4:0] r2, input logic [5:0] opc, input logic [4:0] r1);
    return {r2, opc, r1};
  endfunction

  initial begin
    logic [DW-1:0] v;
    bit mismatch;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    {mCy, mOv, mS, mZ, mIll} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkEq("R1 flags", {28'h0, flagCy, flagOv, flagS, flagZ}, '0);
    checkEq("R1 illegal", {31'h0, illegalOp}, '0);
    mismatch = 0;
    for (int i = 0; i < 32; i++) begin
      readReg(i[4:0], v);
      if (v !== '0) mismatch = 1;
    end
    checkEq("R1 registers zero", {31'h0, mismatch}, '0);

    // Loads through XORI from r0 (R7), including an idle gap
    runInstr(enc(5'd1, 6'b110101, 5'd0), 16'h0001, 0);
    runInstr(enc(5'd2, 6'b110101, 5'd0), 16'h8080, 3);
    // R2: write to r0 discarded
    runInstr(enc(5'd0, 6'b110101, 5'd2), 16'h1234, 1);
    readReg(5'd0, v);
    checkEq("R2 r0 still zero", v, '0);
    // R3 borrow: r4 = 0 - 1
    runInstr(enc(5'd4, 6'b001101, 5'd1), 16'h0, 0);
    checkEq("R3 borrow CY", {31'h0, flagCy}, 32'd1);
    readReg(5'd4, v);
    checkEq("R3 0-1 result", v, 32'hFFFF_FFFF);
    // R3 zero flag
    runInstr(enc(5'd5, 6'b110101, 5'd0), 16'h0001, 0);
    runInstr(enc(5'd5, 6'b001101, 5'd1), 16'h0, 0);
    checkEq("R3 equal sets Z", {31'h0, flagZ}, 32'd1);
    // R8 extensions of 0x8080
    runInstr(enc(5'd6, 6'b110101, 5'd2), 16'h0000, 0);
    runInstr(enc(5'd0, 6'b000101, 5'd6), 16'h0, 0);
    readReg(5'd6, v);
    checkEq("R8 sign-extend byte", v, 32'hFFFF_FF80);
    runInstr(enc(5'd0, 6'b000110, 5'd6), 16'h0, 0);
    readReg(5'd6, v);
    checkEq("R8 zero-extend half", v, 32'h0000_FF80);
    runInstr(enc(5'd0, 6'b000111, 5'd2), 16'h0, 0);
    runInstr(enc(5'd0, 6'b000100, 5'd6), 16'h0, 0);
    // Build 0x80000000 in r8 by doubling (R4, R6, R9 back to back)
    runInstr(enc(5'd8, 6'b110101, 5'd0), 16'h0001, 0);
    for (int k = 0; k < 31; k++) begin
      runInstr(enc(5'd10, 6'b001001, 5'd10), 16'h0, 0);
      runInstr(enc(5'd10, 6'b001100, 5'd0), 16'h0, 0);
      runInstr(enc(5'd10, 6'b001100, 5'd0), 16'h0, 0);
      runInstr(enc(5'd10, 6'b001101, 5'd8), 16'h0, 0);
      runInstr(enc(5'd8, 6'b001101, 5'd10), 16'h0, 0);
    end
    readReg(5'd8, v);
    checkEq("R3 doubling reached top bit", v, 32'h8000_0000);
    // R3 signed overflow: 0x80000000 - 1
    runInstr(enc(5'd8, 6'b001101, 5'd1), 16'h0, 0);
    checkEq("R3 overflow OV", {31'h0, flagOv}, 32'd1);
    // R5 test leaves registers alone
    runInstr(enc(5'd8, 6'b001011, 5'd4), 16'h0, 0);
    readReg(5'd8, v);
    checkEq("R5 no write", v, 32'h7FFF_FFFF);
    // R10 illegal: extension with reg2 nonzero, then pulse drops when idle
    runInstr(enc(5'd3, 6'b000101, 5'd6), 16'h0, 0);
    checkEq("R10 pulse", {31'h0, illegalOp}, 32'd1);
    @(negedge clk);
    checkEq("R10 pulse one cycle", {31'h0, illegalOp}, '0);
    readReg(5'd6, v);
    checkEq("R10 no write", v, peek(5'd6));

    // Seeded random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] r1, r2;
      logic [5:0] opc;
      int kind;
      r1 = $urandom_range(0, 31);
      r2 = $urandom_range(0, 31);
      kind = $urandom_range(0, 10);
      case (kind)
        0, 8: opc = 6'b001101;
        1, 9: opc = 6'b001100;
        2: opc = 6'b001011;
        3: opc = 6'b001001;
        4, 10: opc = 6'b110101;
        5, 6: begin
          opc = {4'b0001, 2'($urandom_range(0, 3))};
          if ($urandom_range(0, 9) != 0) r2 = 0;
        end
        default: begin
          opc = $urandom();
          while (isLegal(opc, 5'd1)) opc = $urandom();
        end
      endcase
      runInstr(enc(r2, opc, r1), 16'($urandom()), $urandom_range(0, 2));
    end

    // Final sweep of the whole register file
    mismatch = 0;
    for (int i = 0; i < 32; i++) begin
      readReg(i[4:0], v);
      if (v !== peek(i[4:0])) mismatch = 1;
    end
    checkEq("R9 final register file", {31'h0, mismatch}, '0);
    summary();
  end
endmodule